// File: doc/BRIEF.md
# Extension Field Polynomial Multiplier

This block multiplies two elements of a simple extension of a prime field. Each element has DEG coefficients modulo a prime P, and coefficient 0 is the constant term. A third operand gives the coefficients a_i of a monic irreducible polynomial. It is written so that x^DEG equals the sum of a_i·x^i, which means a high-order term is added back into the lower terms, never subtracted.

The block works one term at a time. It first forms the schoolbook product in 2·DEG−1 accumulation slots, with every partial product and every sum reduced mod P. Then it folds the slots from degree 2·DEG−2 down to DEG into the lower slots, highest degree first, by substituting the irreducible polynomial. The lowest DEG slots form the result. The slots above them are not cleared; they are simply never presented at the output. Each reduction of a product uses an iterative shift-and-subtract over 2·W bits, where W is the coefficient width.

Control is a plain start/busy/done handshake, and there is no back-pressure on the output. A start pulse while the block is idle captures all operands and the prime. The caller only has to hold the operands for that one cycle. The result bus keeps its value from the done pulse until the next accepted start. A start that arrives while the block is busy is ignored.

Top module: `ext_field_mul`

## Requirements
- R1: After reset, busy and done are low and every result coefficient is zero.
- R2: A start while busy is low captures lhs, rhs, poly and prime, and busy is high in the next cycle.
- R3: The product lhs[i]·rhs[j] reduced mod P is accumulated mod P into slot i+j for all i, j. An operand of all zero coefficients gives a zero result.
- R4: Slots from degree 2·DEG−2 down to DEG are folded in descending order. For each j, slot[k]·a_j is added mod P into slot k−DEG+j, so x^DEG is replaced by the sum of a_j·x^j.
- R5: The result carries DEG coefficients in ascending power order. Coefficient n occupies bits [n·W+W−1 : n·W], the same packing as lhs, rhs and poly.
- R6: Given inputs below P, every result coefficient is strictly less than P when done is high.
- R7: Done is high for exactly one cycle and only while busy, and busy is low in the following cycle. While busy is low and start is low, the result does not change.
- R8: Start is ignored while busy. The operation already running completes with its captured operands.
- R9: With DEG=2 and poly a0=P−1, a1=0 (x^2 = −1), the result is (b·c + a·d) mod P at coefficient 1 and (a·c − b·d) mod P at coefficient 0, for lhs = a + b·x and rhs = c + d·x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only while busy is low |
| lhs_i | input | DEG·W | Left operand coefficients, constant term in the low W bits |
| rhs_i | input | DEG·W | Right operand coefficients, same packing |
| poly_i | input | DEG·W | Irreducible polynomial coefficients a_i, same packing |
| prime_i | input | W | Field modulus P |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | DEG·W | Product coefficients, constant term in the low W bits |

## Verification
The bound checker watches the handshake on every cycle. It checks that an accepted start raises busy, that busy cannot drop before done, that done is a lone pulse followed by idle, and that the result holds while the block is idle. Against a prime captured in the checker itself, it also checks that every coefficient is below P at done. The arithmetic can only be shown by the bench scenarios: slot placement, the top-down fold with added high terms, coefficient ordering, the x^2 = −1 case on a second instance, and a start ignored mid-operation. These are all compared with a model written from the requirements.

// File: rtl/efm_pkg.sv
package efm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } efm_state_e;

  typedef enum logic {
    PH_MUL  = 1'b0,
    PH_FOLD = 1'b1
  } efm_phase_e;
endpackage

// File: rtl/efm_mulmod.sv
// Computes x*y mod p: full product first, then one remainder bit per cycle.
module efm_mulmod #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] p,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(PW + 1);

  logic [PW-1:0] prod;
  logic [W-1:0]  rem;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic [W:0]    nxt;

  always_comb begin
    trial = {rem, prod[PW-1]};
    if (trial >= {1'b0, p}) nxt = trial - {1'b0, p};
    else                    nxt = trial;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod <= '0;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        prod <= {{W{1'b0}}, x} * {{W{1'b0}}, y};
        rem  <= '0;
        cnt  <= CW'(PW);
        run  <= 1'b1;
      end else if (run) begin
        prod <= prod << 1;
        rem  <= nxt[W-1:0];
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign res = rem;
endmodule

// File: rtl/efm_addmod.sv
// (a + b) mod p for a, b already below p.
module efm_addmod #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] p,
  output logic [W-1:0] s
);
  logic [W:0] sum;
  logic [W:0] red;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    if (sum >= {1'b0, p}) red = sum - {1'b0, p};
    else                  red = sum;
    s = red[W-1:0];
  end
endmodule

// File: rtl/efm_ctrl.sv
// Walks the product pass (i, j) and then the fold pass (k high to low, j).
module efm_ctrl
  import efm_pkg::*;
#(
  parameter int DEG = 4,
  parameter int IW  = $clog2(2 * DEG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mm_done,
  output logic          load,
  output logic          mm_start,
  output logic          acc_en,
  output efm_phase_e    phase,
  output logic [IW-1:0] idx_a,
  output logic [IW-1:0] idx_b,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEG - 1);
  localparam logic [IW-1:0] TOP_IDX  = IW'(2 * DEG - 2);
  localparam logic [IW-1:0] LOW_FOLD = IW'(DEG);

  efm_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_MUL;
      idx_a <= '0;
      idx_b <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          phase <= PH_MUL;
          idx_a <= '0;
          idx_b <= '0;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (mm_done) begin
          if (idx_b != LAST_IDX) begin
            idx_b <= idx_b + 1'b1;
            state <= ST_ISSUE;
          end else begin
            idx_b <= '0;
            if (phase == PH_MUL) begin
              state <= ST_ISSUE;
              if (idx_a != LAST_IDX) begin
                idx_a <= idx_a + 1'b1;
              end else begin
                phase <= PH_FOLD;
                idx_a <= TOP_IDX;
              end
            end else if (idx_a != LOW_FOLD) begin
              idx_a <= idx_a - 1'b1;
              state <= ST_ISSUE;
            end else begin
              state <= ST_FIN;
            end
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load     = (state == ST_IDLE) && start;
  assign mm_start = (state == ST_ISSUE);
  assign acc_en   = (state == ST_WAIT) && mm_done;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/ext_field_mul.sv
module ext_field_mul
  import efm_pkg::*;
#(
  parameter int W   = 16,
  parameter int DEG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEG*W-1:0] lhs_i,
  input  logic [DEG*W-1:0] rhs_i,
  input  logic [DEG*W-1:0] poly_i,
  input  logic [W-1:0]     prime_i,
  output logic             busy,
  output logic             done,
  output logic [DEG*W-1:0] result
);
  localparam int NSLOT = 2 * DEG - 1;
  localparam int IW    = $clog2(2 * DEG);

  logic [DEG*W-1:0] lhs_q, rhs_q, poly_q;
  logic [W-1:0]     p_q;
  logic [W-1:0]     slot [NSLOT];

  logic             load, mm_start, acc_en, mm_done;
  efm_phase_e       phase;
  logic [IW-1:0]    idx_a, idx_b, dst;
  logic [W-1:0]     mm_x, mm_y, mm_res, acc_sum;

  efm_ctrl #(.DEG(DEG), .IW(IW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mm_done(mm_done),
    .load(load), .mm_start(mm_start), .acc_en(acc_en), .phase(phase),
    .idx_a(idx_a), .idx_b(idx_b), .busy(busy), .done(done)
  );

  // Product pass takes operand coefficients; fold pass takes a high slot and a_j.
  always_comb begin
    if (phase == PH_MUL) begin
      mm_x = lhs_q[int'(idx_a)*W +: W];
      mm_y = rhs_q[int'(idx_b)*W +: W];
      dst  = idx_a + idx_b;
    end else begin
      mm_x = slot[idx_a];
      mm_y = poly_q[int'(idx_b)*W +: W];
      dst  = idx_a - IW'(DEG) + idx_b;
    end
  end

  efm_mulmod #(.W(W)) i_mulmod (
    .clk(clk), .rst_n(rst_n), .start(mm_start),
    .x(mm_x), .y(mm_y), .p(p_q), .done(mm_done), .res(mm_res)
  );

  efm_addmod #(.W(W)) i_addmod (
    .a(slot[dst]), .b(mm_res), .p(p_q), .s(acc_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lhs_q  <= '0;
      rhs_q  <= '0;
      poly_q <= '0;
      p_q    <= '0;
      for (int n = 0; n < NSLOT; n++) slot[n] <= '0;
    end else if (load) begin
      lhs_q  <= lhs_i;
      rhs_q  <= rhs_i;
      poly_q <= poly_i;
      p_q    <= prime_i;
      for (int n = 0; n < NSLOT; n++) slot[n] <= '0;
    end else if (acc_en) begin
      slot[dst] <= acc_sum;
    end
  end

  for (genvar g = 0; g < DEG; g++) begin : g_res
    assign result[g*W +: W] = slot[g];
  end
endmodule

// File: rtl/ext_field_mul_chk.sv
module ext_field_mul_chk #(
  parameter int W   = 16,
  parameter int DEG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [W-1:0]     prime_i,
  input logic [DEG*W-1:0] result
);
  logic [W-1:0] p_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)              p_cap <= '0;
    else if (start && !busy) p_cap <= prime_i;
  end

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result));

  for (genvar g = 0; g < DEG; g++) begin : g_lt
    p_below_prime_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result[g*W +: W] < p_cap);
  end
endmodule

bind ext_field_mul ext_field_mul_chk #(.W(W), .DEG(DEG)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .prime_i(prime_i), .result(result)
);

// File: tb/test_ext_field_mul.sv
`timescale 1ns/1ps
module test_ext_field_mul;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start4 = 1'b0, busy4, done4;
  logic [63:0] lhs4 = '0, rhs4 = '0, poly4 = '0, res4;
  logic [15:0] p4 = '0;

  logic        start2 = 1'b0, busy2, done2;
  logic [31:0] lhs2 = '0, rhs2 = '0, poly2 = '0, res2;
  logic [15:0] p2 = '0;

  int checks = 0;
  int errors = 0;

  ext_field_mul #(.W(W), .DEG(4)) i_ext_field_mul (
    .clk(clk), .rst_n(rst_n), .start(start4), .lhs_i(lhs4), .rhs_i(rhs4),
    .poly_i(poly4), .prime_i(p4), .busy(busy4), .done(done4), .result(res4)
  );

  ext_field_mul #(.W(W), .DEG(2)) i_ext_field_mul_d2 (
    .clk(clk), .rst_n(rst_n), .start(start2), .lhs_i(lhs2), .rhs_i(rhs2),
    .poly_i(poly2), .prime_i(p2), .busy(busy2), .done(done2), .result(res2)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk4(input longint c0, c1, c2, c3);
    return {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
  endfunction

  // Model from R3/R4: schoolbook slots mod P, then fold from the top down.
  function automatic logic [63:0] ref4(input logic [63:0] a, b, q, input longint p);
    longint s[7];
    logic [63:0] r;
    for (int k = 0; k < 7; k++) s[k] = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        s[i+j] = (s[i+j] + (longint'(a[i*16 +: 16]) * longint'(b[j*16 +: 16])) % p) % p;
    for (int k = 6; k >= 4; k--)
      for (int j = 0; j < 4; j++)
        s[k-4+j] = (s[k-4+j] + (s[k] * longint'(q[j*16 +: 16])) % p) % p;
    r = '0;
    for (int n = 0; n < 4; n++) r[n*16 +: 16] = 16'(s[n]);
    return r;
  endfunction

  task automatic wait_done4(input string req);
    int t = 0;
    while (!done4 && t < 20000) begin @(negedge clk); t++; end
    check(done4, req, 64'(t), 64'(0));
  endtask

  task automatic run4(input logic [63:0] a, b, q, input logic [15:0] p, input string req);
    @(negedge clk);
    lhs4 = a; rhs4 = b; poly4 = q; p4 = p; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    check(busy4 === 1'b1, "R2 busy after start", 64'(busy4), 64'(1));
    wait_done4(req);
    check(res4 === ref4(a, b, q, longint'(p)), req, res4, ref4(a, b, q, longint'(p)));
    @(negedge clk);
    check(!done4 && !busy4, "R7 done single pulse then idle", {62'd0, done4, busy4}, 64'(0));
  endtask

  task automatic t_reset();
    check(!busy4 && !done4 && res4 == '0, "R1 reset state deg4", res4, 64'(0));
    check(!busy2 && !done2 && res2 == '0, "R1 reset state deg2", 64'(res2), 64'(0));
  endtask

  task automatic t_general();
    run4(pk4(1234, 56, 7890, 3), pk4(999, 40000, 12, 65000), pk4(7, 0, 3, 11), 16'd65521,
         "R3 R4 general product");
    run4(pk4(0, 0, 0, 0), pk4(5, 6, 7, 8), pk4(1, 2, 3, 4), 16'd65521, "R3 zero operand");
  endtask

  task automatic t_order();
    // 1 * rhs must return rhs unchanged, coefficient n at bits n*16.
    run4(pk4(1, 0, 0, 0), pk4(5, 6, 7, 8), pk4(9, 9, 9, 9), 16'd101, "R5 ascending order");
    check(res4 === pk4(5, 6, 7, 8), "R5 identity", res4, pk4(5, 6, 7, 8));
  endtask

  task automatic t_fold();
    // x * x^3 = x^4 = sum a_j x^j, so the result equals poly (added, not subtracted).
    run4(pk4(0, 1, 0, 0), pk4(0, 0, 0, 1), pk4(3, 5, 7, 2), 16'd97, "R4 single fold");
    check(res4 === pk4(3, 5, 7, 2), "R4 x^4 replaced by poly", res4, pk4(3, 5, 7, 2));
    // x^3 * x^3 = x^6 needs the top-down chain through slot 5 and 4.
    run4(pk4(0, 0, 0, 1), pk4(0, 0, 0, 1), pk4(3, 5, 7, 2), 16'd97, "R4 chained fold");
  endtask

  task automatic t_max();
    run4(pk4(65520, 65520, 65520, 65520), pk4(65520, 65520, 65520, 65520),
         pk4(65520, 65520, 65520, 65520), 16'd65521, "R6 all P-1");
    for (int n = 0; n < 4; n++)
      check(res4[n*16 +: 16] < 16'd65521, "R6 coefficient below P", 64'(res4[n*16 +: 16]), 64'(65521));
  endtask

  task automatic t_start_busy();
    logic [63:0] a = pk4(11, 22, 33, 44), b = pk4(55, 66, 77, 88), q = pk4(2, 0, 0, 1);
    logic [63:0] e = ref4(a, b, q, 251);
    @(negedge clk);
    lhs4 = a; rhs4 = b; poly4 = q; p4 = 16'd251; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    repeat (20) @(negedge clk);
    lhs4 = pk4(1, 1, 1, 1); rhs4 = pk4(2, 2, 2, 2); p4 = 16'd13; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    check(busy4 === 1'b1, "R8 still busy after ignored start", 64'(busy4), 64'(1));
    wait_done4("R8 done after ignored start");
    check(res4 === e, "R8 start ignored while busy", res4, e);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [63:0] keep = res4;
    lhs4 = pk4(3, 3, 3, 3); rhs4 = pk4(4, 4, 4, 4); p4 = 16'd7;
    repeat (10) @(negedge clk);
    check(res4 === keep && !busy4, "R7 result held while idle", res4, keep);
  endtask

  task automatic t_deg2(input longint a, b, c, d, input longint p);
    longint e0 = ((a * c - b * d) % p + p) % p;
    longint e1 = (b * c + a * d) % p;
    int t = 0;
    @(negedge clk);
    lhs2 = {16'(b), 16'(a)}; rhs2 = {16'(d), 16'(c)};
    poly2 = {16'd0, 16'(p - 1)}; p2 = 16'(p); start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    while (!done2 && t < 20000) begin @(negedge clk); t++; end
    check(done2, "R9 deg2 done", 64'(t), 64'(0));
    check(res2 === {16'(e1), 16'(e0)}, "R9 x^2 = -1 product", 64'(res2), 64'({16'(e1), 16'(e0)}));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_general();
    t_order();
    t_fold();
    t_max();
    t_start_busy();
    t_hold();
    t_deg2(3, 4, 5, 6, 65521);
    t_deg2(65520, 65520, 65520, 1, 65521);
    t_deg2(0, 7, 0, 9, 13);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule